// File: doc/BRIEF.md
# Load-Use Stall Counter

This block watches the stream of retiring instructions and counts the pipeline bubbles that a load-use dependency would cost. Each retire presents up to two source register indices, each with its own valid flag, and an optional destination index that the instruction holds locked until its data arrives. The block keeps only the lock left by the instruction just before. When a valid source of the current instruction equals that held lock, it raises a one-cycle stall pulse and bumps a stall count.

On every retire the held lock is replaced by the lock of the retiring instruction, or by a reserved "no lock" code when the instruction locks nothing. That code is outside the general register range, so it never causes a stall. Alongside the stall count the block keeps an instruction count and a cycle count. Both advance by one per retire. All three counts saturate at all-ones. A synchronous clear returns the counts and the held lock to their starting state.

Top module: `hazard_stall_counter`

## Requirements
- R1: In a cycle with `retire_i` high and `clear_i` low, `stall_o` is high in that same cycle when `src0_vld_i` is high and `src0_idx_i` equals the held lock. `stall_cnt_o` is one higher after the clock edge.
- R2: When both sources are valid and either or both of them equal the held lock, `stall_o` is high once and `stall_cnt_o` rises by exactly one.
- R3: After a retire with `lock_vld_i` high, the held lock is `lock_idx_i`; after a retire with `lock_vld_i` low, it is the no-lock code. Cycles without a retire leave it unchanged.
- R4: The no-lock code is the value 30 (parameter `NONE_CODE`). While the held lock is 30, no stall occurs, even when a valid source index is 30.
- R5: A source whose valid flag is low never causes a stall, whatever its index.
- R6: Each retire raises `inst_cnt_o` and `cycle_cnt_o` by one. Cycles without a retire leave all three counts unchanged, and `stall_o` is low in those cycles.
- R7: Each count saturates at all-ones (2^CNT_W-1) and holds there until it is cleared.
- R8: `clear_i` zeroes all three counts and sets the held lock to the no-lock code at the next edge. It takes priority over a retire in the same cycle: no stall pulse, no count changes, and the retiring instruction's lock is discarded.
- R9: After reset, all counts are zero, `stall_o` is low and the held lock is the no-lock code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear_i | input | 1 | Synchronous clear of counts and held lock |
| retire_i | input | 1 | One instruction retires this cycle |
| src0_vld_i | input | 1 | First source index is meaningful |
| src0_idx_i | input | IDX_W | First source register index |
| src1_vld_i | input | 1 | Second source index is meaningful |
| src1_idx_i | input | IDX_W | Second source register index |
| lock_vld_i | input | 1 | Retiring instruction locks a register |
| lock_idx_i | input | IDX_W | Register locked by the retiring instruction |
| stall_o | output | 1 | Load-use hazard detected in this retire cycle |
| stall_cnt_o | output | CNT_W | Saturating stall count |
| inst_cnt_o | output | CNT_W | Saturating instruction count |
| cycle_cnt_o | output | CNT_W | Saturating cycle count |

## Verification
The bench builds the block with CNT_W of 4 and keeps IDX_W at 5 and NONE_CODE at 30. The narrow counts reach saturation within fifteen retires, so the hold at all-ones is exercised many times between random clears. The 5-bit index range lets a valid source carry the value 30, which tests that the no-lock code never matches. Random sources are drawn from a small pool near the locked values, so matches on one source, on both sources and on an invalid source all occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned HZ_IDX_W     = 5;
  localparam int unsigned HZ_CNT_W     = 32;
  localparam int unsigned HZ_NONE_CODE = 30;
  localparam int unsigned HZ_NSRC      = 2;

  typedef enum int unsigned {
    SLOT_STALL = 0,
    SLOT_INST  = 1,
    SLOT_CYCLE = 2,
    SLOT_COUNT = 3
  } hz_slot_e;
endpackage

// File: rtl/hz_lock_track.sv
module hz_lock_track #(
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned NSRC      = 2,
  parameter int unsigned NONE_CODE = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       retire_i,
  input  logic [NSRC-1:0]            src_vld_i,
  input  logic [NSRC-1:0][IDX_W-1:0] src_idx_i,
  input  logic                       lock_vld_i,
  input  logic [IDX_W-1:0]           lock_idx_i,
  output logic                       hit_o
);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NONE_CODE);

  logic [IDX_W-1:0] held_q;
  logic [IDX_W-1:0] held_d;
  logic             held_en;
  logic [NSRC-1:0]  src_hit;
  logic             held_live;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign src_hit[g] = src_vld_i[g] && (src_idx_i[g] == held_q);
    end
  endgenerate

  assign held_live = (held_q != NONE_IDX);
  assign hit_o     = retire_i && !clear_i && held_live && (|src_hit);

  always_comb begin
    held_en = clear_i || retire_i;
    if (clear_i) begin
      held_d = NONE_IDX;
    end else if (lock_vld_i) begin
      held_d = lock_idx_i;
    end else begin
      held_d = NONE_IDX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= NONE_IDX;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/hz_sat_counter.sv
module hz_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != TOP));
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/hazard_stall_counter.sv
module hazard_stall_counter
  import hz_pkg::*;
#(
  parameter int unsigned IDX_W     = HZ_IDX_W,
  parameter int unsigned CNT_W     = HZ_CNT_W,
  parameter int unsigned NONE_CODE = HZ_NONE_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             retire_i,
  input  logic             src0_vld_i,
  input  logic [IDX_W-1:0] src0_idx_i,
  input  logic             src1_vld_i,
  input  logic [IDX_W-1:0] src1_idx_i,
  input  logic             lock_vld_i,
  input  logic [IDX_W-1:0] lock_idx_i,
  output logic             stall_o,
  output logic [CNT_W-1:0] stall_cnt_o,
  output logic [CNT_W-1:0] inst_cnt_o,
  output logic [CNT_W-1:0] cycle_cnt_o
);
  localparam int unsigned NCNT = SLOT_COUNT;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [HZ_NSRC-1:0]            src_vld;
  logic [HZ_NSRC-1:0][IDX_W-1:0] src_idx;
  logic                          hit;
  logic                          retire_go;

  assign src_vld    = {src1_vld_i, src0_vld_i};
  assign src_idx[0] = src0_idx_i;
  assign src_idx[1] = src1_idx_i;
  assign retire_go  = retire_i && !clear_i;

  hz_lock_track #(
    .IDX_W    (IDX_W),
    .NSRC     (HZ_NSRC),
    .NONE_CODE(NONE_CODE)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (clear_i),
    .retire_i  (retire_i),
    .src_vld_i (src_vld),
    .src_idx_i (src_idx),
    .lock_vld_i(lock_vld_i),
    .lock_idx_i(lock_idx_i),
    .hit_o     (hit)
  );

  logic [NCNT-1:0]            cnt_inc;
  logic [NCNT-1:0][CNT_W-1:0] cnt_val;

  assign cnt_inc[SLOT_STALL] = hit;
  assign cnt_inc[SLOT_INST]  = retire_go;
  assign cnt_inc[SLOT_CYCLE] = retire_go;

  genvar c;
  generate
    for (c = 0; c < NCNT; c++) begin : g_cnt
      hz_sat_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .clr_i  (clear_i),
        .inc_i  (cnt_inc[c]),
        .count_o(cnt_val[c])
      );
    end
  endgenerate

  assign stall_o     = hit;
  assign stall_cnt_o = cnt_val[SLOT_STALL];
  assign inst_cnt_o  = cnt_val[SLOT_INST];
  assign cycle_cnt_o = cnt_val[SLOT_CYCLE];
endmodule

// File: rtl/hazard_stall_counter_chk.sv
module hazard_stall_counter_chk #(
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NONE_CODE = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             retire_i,
  input logic             src0_vld_i,
  input logic [IDX_W-1:0] src0_idx_i,
  input logic             src1_vld_i,
  input logic             lock_vld_i,
  input logic [IDX_W-1:0] lock_idx_i,
  input logic             stall_o,
  input logic [CNT_W-1:0] stall_cnt_o,
  input logic [CNT_W-1:0] inst_cnt_o,
  input logic [CNT_W-1:0] cycle_cnt_o
);
  localparam logic [CNT_W-1:0] TOP      = '1;
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NONE_CODE);

  assert_stall_counted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && stall_cnt_o != TOP) |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1);

  assert_stall_only_on_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (retire_i && !clear_i));

  assert_match_after_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !clear_i && lock_vld_i && lock_idx_i != NONE_IDX) |=>
    (!(retire_i && !clear_i && src0_vld_i && src0_idx_i == $past(lock_idx_i)) || stall_o));

  assert_no_stall_after_nolock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !clear_i && !lock_vld_i) |=> !stall_o);

  assert_stall_needs_valid_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (src0_vld_i || src1_vld_i));

  assert_inst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !clear_i && inst_cnt_o != TOP) |=> inst_cnt_o == $past(inst_cnt_o) + 1'b1);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !clear_i) |=> ($stable(inst_cnt_o) && $stable(stall_cnt_o) && $stable(cycle_cnt_o)));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_cnt_o == TOP && !clear_i) |=> inst_cnt_o == TOP);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (stall_cnt_o == '0 && inst_cnt_o == '0 && cycle_cnt_o == '0));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_stall_le_inst_R2: assert (stall_cnt_o <= inst_cnt_o);
      assert_cycle_tracks_inst_R6: assert (cycle_cnt_o == inst_cnt_o);
    end
  end
endmodule

bind hazard_stall_counter hazard_stall_counter_chk #(
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W),
  .NONE_CODE(NONE_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .clear_i    (clear_i),
  .retire_i   (retire_i),
  .src0_vld_i (src0_vld_i),
  .src0_idx_i (src0_idx_i),
  .src1_vld_i (src1_vld_i),
  .lock_vld_i (lock_vld_i),
  .lock_idx_i (lock_idx_i),
  .stall_o    (stall_o),
  .stall_cnt_o(stall_cnt_o),
  .inst_cnt_o (inst_cnt_o),
  .cycle_cnt_o(cycle_cnt_o)
);

// File: tb/hazard_stall_counter_test.sv
module hazard_stall_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 5;
  localparam int CNT_W      = 4;
  localparam int NONE_CODE  = 30;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             clear_i, retire_i;
  logic             src0_vld_i, src1_vld_i, lock_vld_i;
  logic [IDX_W-1:0] src0_idx_i, src1_idx_i, lock_idx_i;
  logic             stall_o;
  logic [CNT_W-1:0] stall_cnt_o, inst_cnt_o, cycle_cnt_o;

  int n_checks = 0;
  int n_fails  = 0;

  int m_prev  = NONE_CODE;
  int m_stall = 0;
  int m_inst  = 0;

  hazard_stall_counter #(.IDX_W(IDX_W), .CNT_W(CNT_W), .NONE_CODE(NONE_CODE)) uut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .retire_i(retire_i),
    .src0_vld_i(src0_vld_i), .src0_idx_i(src0_idx_i),
    .src1_vld_i(src1_vld_i), .src1_idx_i(src1_idx_i),
    .lock_vld_i(lock_vld_i), .lock_idx_i(lock_idx_i),
    .stall_o(stall_o), .stall_cnt_o(stall_cnt_o),
    .inst_cnt_o(inst_cnt_o), .cycle_cnt_o(cycle_cnt_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat_inc(int v);
    return (v == CMAX) ? v : v + 1;
  endfunction

  function automatic bit exp_stall(bit r, bit c, bit v0, int s0, bit v1, int s1);
    return r && !c && (m_prev != NONE_CODE) &&
           ((v0 && s0 == m_prev) || (v1 && s1 == m_prev));
  endfunction

  task automatic step(bit r, bit v0, int s0, bit v1, int s1, bit lv, int l, bit c, string tag);
    bit e;
    @(negedge clk);
    retire_i = r; src0_vld_i = v0; src0_idx_i = IDX_W'(s0);
    src1_vld_i = v1; src1_idx_i = IDX_W'(s1);
    lock_vld_i = lv; lock_idx_i = IDX_W'(l); clear_i = c;
    #1;
    e = exp_stall(r, c, v0, s0, v1, s1);
    check({tag, " stall_o"}, int'(stall_o), int'(e));
    @(posedge clk);
    if (c) begin
      m_stall = 0; m_inst = 0; m_prev = NONE_CODE;
    end else if (r) begin
      m_inst = sat_inc(m_inst);
      if (e) m_stall = sat_inc(m_stall);
      m_prev = lv ? l : NONE_CODE;
    end
    #1;
    check({tag, " stall_cnt"}, int'(stall_cnt_o), m_stall);
    check({tag, " inst_cnt"},  int'(inst_cnt_o),  m_inst);
    check({tag, " cycle_cnt"}, int'(cycle_cnt_o), m_inst);
  endtask

  function automatic int pick_idx();
    int k = $urandom_range(0, 7);
    if (k == 7) return NONE_CODE;
    return k % 4;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; clear_i = 0; retire_i = 0;
    src0_vld_i = 0; src1_vld_i = 0; lock_vld_i = 0;
    src0_idx_i = '0; src1_idx_i = '0; lock_idx_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset stall_o",   int'(stall_o), 0);
    check("R9 reset stall_cnt", int'(stall_cnt_o), 0);
    check("R9 reset inst_cnt",  int'(inst_cnt_o), 0);
    check("R9 reset cycle_cnt", int'(cycle_cnt_o), 0);
    // held lock is the no-lock code after reset: no match even on 30
    step(1, 1, 30, 1, 0, 1, 5, 0, "R9 R4 first retire");
    step(1, 1, 5, 0, 0, 1, 7, 0, "R1 src0 match");
    step(1, 1, 7, 1, 7, 0, 0, 0, "R2 both match");
    step(1, 1, 30, 1, 30, 1, 3, 0, "R4 none code no match");
    step(1, 0, 3, 0, 3, 1, 4, 0, "R5 invalid srcs");
    step(0, 1, 4, 1, 4, 0, 0, 0, "R6 idle");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6 idle again");
    step(1, 0, 0, 1, 4, 1, 9, 0, "R3 lock held over idle");
    step(1, 1, 9, 0, 0, 1, 11, 1, "R8 clear beats retire");
    step(1, 1, 11, 1, 9, 1, 2, 0, "R8 lock dropped by clear");
    step(1, 1, 2, 0, 0, 1, 30, 0, "R3 lock code 30");
    step(1, 1, 30, 0, 0, 1, 6, 0, "R4 held 30 is no lock");
    for (int i = 0; i < 20; i++) step(1, 1, 6, 0, 0, 1, 6, 0, "R7 saturate");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R8 clear after saturate");
    for (int i = 0; i < 400; i++) begin
      bit c  = ($urandom_range(0, 39) == 0);
      bit r  = ($urandom_range(0, 3) != 0);
      bit v0 = $urandom_range(0, 1);
      bit v1 = $urandom_range(0, 1);
      bit lv = ($urandom_range(0, 3) != 0);
      step(r, v0, pick_idx(), v1, pick_idx(), lv, pick_idx(), c, "R1 R2 R3 R6 R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule